// File: doc/BRIEF.md
# Strap Sampling and Pin Turnaround Controller

This block captures board-level configuration from pins that are shared between strap inputs and clock outputs. An external comparator reports each pin as a 2-bit level code (low, mid or high). The block captures the codes once after reset and again on each release of the power-down request. It then waits a set number of slow reference ticks, nominally 10 ms, while the shared pins stay inputs. After that it enables the pin drivers and reports the configuration as valid.

The captured levels are decoded into fields for the clock generator that sits downstream: the PCI clock frequency, which also carries the global tristate condition; the audio clock frequency; the fixed-clock frequency; which of two PCI outputs run free while the PCI clocks are stopped; early PCI timing; and spread-spectrum enable. Three pins take three levels. The others are two-level, and on those anything other than low reads as high. Before the first capture, every field shows its power-on default.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: While reset is held and until the first capture, `cfg_valid_o` is 0, `pin_oe_o` is 0 and the fields show their defaults: `pci_freq_o`=3, `aud_freq_o`=1, `fix_sel_o`=1, `pcif_map_o`=2'b01, `early_pci_o`=0, `spread_en_o`=0, `tristate_o`=0.
- R2: The controller captures `strap_lvl_i` on the second clock edge after reset is released with `pd_req_i` low, or after `pd_req_i` falls. Pin i occupies bits [2i+1:2i], in the order tristate, PCI-frequency, audio, fixed-select, free-run map, early-PCI and low-EMI. The codes are 2'b00 low, 2'b01 mid and 2'b10 high, and 2'b11 reads as high.
- R3: Between captures, the captured levels and all decoded fields stay unchanged whatever `strap_lvl_i` does.
- R4: `cfg_valid_o` rises on the edge that counts the TURN_TICKS-th `tick_i` pulse after capture. A tick present in the capture cycle itself is not counted, and without ticks the block waits indefinitely.
- R5: When `cfg_valid_o` is 1 and tristate is off, `pin_oe_o` is 7'b1110101: the shared pins 0, 2, 4, 5 and 6. Bits 1 and 3 are never set. Otherwise `pin_oe_o` is 0.
- R6: `pci_freq_o` is decoded from tristate pin T and frequency pin F. T low gives 0 (off) when F is low and 1 (reserved) when F is high. T mid gives 2 (30 MHz) or 3 (33.3 MHz). T high gives 4 (25 MHz) or 5 (37.5 MHz).
- R7: `aud_freq_o` is 0 (16.9344 MHz) for low, 1 (24.576 MHz) for mid and 2 (49.152 MHz) for high.
- R8: `pcif_map_o` bit 0 marks output A as free-running and bit 1 marks output B. The free-run map pin gives 2'b00 for low, 2'b01 for mid and 2'b11 for high.
- R9: `fix_sel_o` is 1 (24 MHz) unless the fixed-select pin is low. `early_pci_o` and `spread_en_o` are 1 only when their active-low pins are low. On these two-level pins, mid reads as high.
- R10: When `pd_req_i` is high, `cfg_valid_o` and `pin_oe_o` are 0 from the next edge. Captured fields are held, and the turnaround restarts in full after the next release.
- R11: `tristate_o` is 1 exactly when T and F are both low. It keeps `pin_oe_o` at 0 even while `cfg_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req_i | input | 1 | Power-down request, active high |
| tick_i | input | 1 | Slow reference tick pulse |
| strap_lvl_i | input | 14 | Comparator level code per pin, 2 bits each |
| cfg_valid_o | output | 1 | Configuration valid and drivers enabled |
| pin_oe_o | output | 7 | Output enable per strap pin |
| pci_freq_o | output | 3 | PCI frequency code |
| aud_freq_o | output | 2 | Audio frequency code |
| fix_sel_o | output | 1 | Fixed-clock select, 1 = 24 MHz |
| pcif_map_o | output | 2 | Free-running map for PCI outputs A and B |
| early_pci_o | output | 1 | Early PCI timing enable |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | All clocks tristated |

## Verification
The hardest cases to reach are those that depend on where the tick counter stands when control changes. The first is a power-down request that arrives partway through the turnaround. The second is a tick that coincides with the capture cycle. The bench holds the tick high across the release so that a miscounted capture cycle would make the valid flag rise one cycle early. It also drops power-down after only part of the ticks have been counted, which shows that the count restarts from zero. A period with no ticks at all shows that the wait does not time out on its own.

// File: rtl/strap_pkg.sv
// Shared constants and types for the strap sampling controller.
// Assumes pin order: 0 tristate, 1 PCI freq, 2 audio, 3 fixed sel,
// 4 free-run map, 5 early PCI (active low), 6 low EMI (active low).
package strap_pkg;
    localparam int NUM_STRAP = 7;
    localparam int LVL_W     = 2;

    localparam int IDX_TS   = 0;
    localparam int IDX_FS   = 1;
    localparam int IDX_AUD  = 2;
    localparam int IDX_SEL  = 3;
    localparam int IDX_MAP  = 4;
    localparam int IDX_EPCI = 5;
    localparam int IDX_EMI  = 6;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    // Pins that resolve three levels
    localparam logic [NUM_STRAP-1:0] TRI_LVL_MASK = 7'b0010101;
    // Pins that turn into clock outputs
    localparam logic [NUM_STRAP-1:0] SHARED_MASK  = 7'b1110101;
    // Power-on levels, pin 6 down to pin 0
    localparam logic [NUM_STRAP*LVL_W-1:0] STRAP_DEFAULT =
        {2'd2, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1};

    typedef enum logic [2:0] {
        PCI_OFF  = 3'd0,
        PCI_RSVD = 3'd1,
        PCI_30   = 3'd2,
        PCI_33   = 3'd3,
        PCI_25   = 3'd4,
        PCI_37   = 3'd5
    } pci_freq_e;

    typedef enum logic [1:0] {
        AUD_16M9 = 2'd0,
        AUD_24M6 = 2'd1,
        AUD_49M2 = 2'd2
    } aud_freq_e;

    typedef enum logic [1:0] {
        SEQ_PWRDN  = 2'd0,
        SEQ_SAMPLE = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/strap_latch.sv
// Normalises and captures the per-pin level codes.
// Assumes sample_i is a single-cycle strobe; holds values otherwise.
// Three-level pins map 2'b11 to high; two-level pins map any non-low to high.
module strap_latch
    import strap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_i,
    input  logic [NUM_STRAP*LVL_W-1:0]    lvl_i,
    output logic [NUM_STRAP*LVL_W-1:0]    lvl_q_o
);
    for (genvar i = 0; i < NUM_STRAP; i++) begin : g_pin
        logic [LVL_W-1:0] raw;
        logic [LVL_W-1:0] norm;
        logic [LVL_W-1:0] held;

        assign raw = lvl_i[i*LVL_W +: LVL_W];

        if (TRI_LVL_MASK[i]) begin : g_tri
            // Fold the unused code onto high
            always_comb norm = (raw == 2'b11) ? LVL_HIGH : raw;
        end else begin : g_two
            // Only low stays low on a two-level pin
            always_comb norm = (raw == LVL_LOW) ? LVL_LOW : LVL_HIGH;
        end

        // Capture on the sample strobe, default level out of reset
        always_ff @(posedge clk) begin
            if (!rst_n)        held <= STRAP_DEFAULT[i*LVL_W +: LVL_W];
            else if (sample_i) held <= norm;
        end

        assign lvl_q_o[i*LVL_W +: LVL_W] = held;
    end
endmodule

// File: rtl/strap_seq.sv
// Power sequencing: idle in power-down, one capture cycle, then a
// tick-counted turnaround before the configuration is declared valid.
// Assumes tick_i is a one-cycle pulse from a slow reference; pd_req_i
// has priority in every state.
module strap_seq
    import strap_pkg::*;
#(
    parameter int TURN_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_i,
    input  logic tick_i,
    output logic sample_o,
    output logic valid_o
);
    localparam int CNT_W = $clog2(TURN_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TURN_TICKS - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    // State and tick counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_PWRDN;
            cnt   <= '0;
        end else if (pd_req_i) begin
            state <= SEQ_PWRDN;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_PWRDN:  state <= SEQ_SAMPLE;
                SEQ_SAMPLE: begin
                    state <= SEQ_WAIT;
                    cnt   <= '0;
                end
                SEQ_WAIT: begin
                    if (tick_i) begin
                        if (cnt == CNT_LAST) state <= SEQ_RUN;
                        else                 cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    // Strobe and valid flag derived from state
    always_comb begin
        sample_o = (state == SEQ_SAMPLE);
        valid_o  = (state == SEQ_RUN);
    end

    AST_PD_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req_i |=> !valid_o); // R10
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(tick_i)); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT) |-> (cnt < CNT_W'(TURN_TICKS))); // R4
endmodule

// File: rtl/strap_decode.sv
// Turns captured pin levels into configuration fields.
// Assumes levels are already normalised (no 2'b11, two-level pins low/high).
module strap_decode
    import strap_pkg::*;
(
    input  logic [NUM_STRAP*LVL_W-1:0] lvl_q_i,
    output logic [2:0]                 pci_freq_o,
    output logic [1:0]                 aud_freq_o,
    output logic                       fix_sel_o,
    output logic [1:0]                 pcif_map_o,
    output logic                       early_pci_o,
    output logic                       spread_en_o,
    output logic                       tristate_o
);
    logic [LVL_W-1:0] ts_l, fs_l, aud_l, sel_l, map_l, epci_l, emi_l;
    pci_freq_e        pci_code;
    aud_freq_e        aud_code;

    assign ts_l   = lvl_q_i[IDX_TS*LVL_W   +: LVL_W];
    assign fs_l   = lvl_q_i[IDX_FS*LVL_W   +: LVL_W];
    assign aud_l  = lvl_q_i[IDX_AUD*LVL_W  +: LVL_W];
    assign sel_l  = lvl_q_i[IDX_SEL*LVL_W  +: LVL_W];
    assign map_l  = lvl_q_i[IDX_MAP*LVL_W  +: LVL_W];
    assign epci_l = lvl_q_i[IDX_EPCI*LVL_W +: LVL_W];
    assign emi_l  = lvl_q_i[IDX_EMI*LVL_W  +: LVL_W];

    // PCI frequency from tristate and frequency pins
    always_comb begin
        case (ts_l)
            LVL_LOW:  pci_code = (fs_l == LVL_LOW) ? PCI_OFF : PCI_RSVD;
            LVL_MID:  pci_code = (fs_l == LVL_LOW) ? PCI_30  : PCI_33;
            default:  pci_code = (fs_l == LVL_LOW) ? PCI_25  : PCI_37;
        endcase
    end

    // Audio frequency from the audio pin
    always_comb begin
        case (aud_l)
            LVL_LOW: aud_code = AUD_16M9;
            LVL_MID: aud_code = AUD_24M6;
            default: aud_code = AUD_49M2;
        endcase
    end

    // Free-running map: bit 0 output A, bit 1 output B
    always_comb begin
        case (map_l)
            LVL_LOW: pcif_map_o = 2'b00;
            LVL_MID: pcif_map_o = 2'b01;
            default: pcif_map_o = 2'b11;
        endcase
    end

    // Two-level and active-low fields
    always_comb begin
        pci_freq_o  = pci_code;
        aud_freq_o  = aud_code;
        fix_sel_o   = (sel_l != LVL_LOW);
        early_pci_o = (epci_l == LVL_LOW);
        spread_en_o = (emi_l == LVL_LOW);
        tristate_o  = (pci_code == PCI_OFF);
    end

    // Output B never runs free unless output A does
    always_comb begin
        AST_MAP_ORDER: assert (!(pcif_map_o[1] && !pcif_map_o[0])); // R8
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
// Top of the strap sampling controller: sequencer, capture register and
// field decoder, plus the per-pin output-enable gating.
// Assumes strap_lvl_i is stable around the capture cycle.
module strap_cfg_ctrl
    import strap_pkg::*;
#(
    parameter int TURN_TICKS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pd_req_i,
    input  logic                       tick_i,
    input  logic [NUM_STRAP*LVL_W-1:0] strap_lvl_i,
    output logic                       cfg_valid_o,
    output logic [NUM_STRAP-1:0]       pin_oe_o,
    output logic [2:0]                 pci_freq_o,
    output logic [1:0]                 aud_freq_o,
    output logic                       fix_sel_o,
    output logic [1:0]                 pcif_map_o,
    output logic                       early_pci_o,
    output logic                       spread_en_o,
    output logic                       tristate_o
);
    logic                       sample;
    logic                       valid;
    logic [NUM_STRAP*LVL_W-1:0] lvl_q;

    strap_seq #(.TURN_TICKS(TURN_TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_req_i (pd_req_i),
        .tick_i   (tick_i),
        .sample_o (sample),
        .valid_o  (valid)
    );

    strap_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .lvl_i    (strap_lvl_i),
        .lvl_q_o  (lvl_q)
    );

    strap_decode u_dec (
        .lvl_q_i     (lvl_q),
        .pci_freq_o  (pci_freq_o),
        .aud_freq_o  (aud_freq_o),
        .fix_sel_o   (fix_sel_o),
        .pcif_map_o  (pcif_map_o),
        .early_pci_o (early_pci_o),
        .spread_en_o (spread_en_o),
        .tristate_o  (tristate_o)
    );

    // Drive shared pins only once valid and not globally tristated
    always_comb begin
        cfg_valid_o = valid;
        pin_oe_o    = (valid && !tristate_o) ? SHARED_MASK : '0;
    end

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(lvl_q)); // R3
    AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o != '0) |-> cfg_valid_o); // R5
    AST_TRI_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        tristate_o |-> (pin_oe_o == '0)); // R11
endmodule

// File: tb/strap_cfg_ctrl_tb.sv
module strap_cfg_ctrl_tb;
    localparam int T = 4;
    localparam logic [1:0] SL = 2'b00, SM = 2'b01, SH = 2'b10, SX = 2'b11;
    localparam logic [6:0] OE_ON = 7'b1110101;

    // {straps(LE,EPCI,MAP,SEL,AUD,FS,TS), pci, aud, fix, map, early, spread, tri}
    localparam logic [24:0] VEC [7] = '{
        {SH,SH,SM,SH,SM,SH,SM, 3'd3, 2'd1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0},
        {SL,SL,SL,SL,SL,SL,SL, 3'd0, 2'd0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1},
        {SL,SH,SH,SH,SH,SH,SL, 3'd1, 2'd2, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0},
        {SH,SL,SL,SM,SX,SL,SM, 3'd2, 2'd2, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0},
        {SM,SM,SX,SL,SL,SL,SH, 3'd4, 2'd0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0},
        {SL,SX,SM,SX,SM,SH,SH, 3'd5, 2'd1, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0},
        {SH,SH,SH,SL,SH,SM,SX, 3'd5, 2'd2, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pd_req;
    logic        tick;
    logic [13:0] straps;
    logic        valid;
    logic [6:0]  oe;
    logic [2:0]  pci;
    logic [1:0]  aud;
    logic        fix;
    logic [1:0]  pmap;
    logic        early;
    logic        spread;
    logic        tri_st;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    strap_cfg_ctrl #(.TURN_TICKS(T)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req_i    (pd_req),
        .tick_i      (tick),
        .strap_lvl_i (straps),
        .cfg_valid_o (valid),
        .pin_oe_o    (oe),
        .pci_freq_o  (pci),
        .aud_freq_o  (aud),
        .fix_sel_o   (fix),
        .pcif_map_o  (pmap),
        .early_pci_o (early),
        .spread_en_o (spread),
        .tristate_o  (tri_st)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_defaults(input string req);
        check({req, " pci"}, pci, 3);
        check({req, " aud"}, aud, 1);
        check({req, " fix"}, fix, 1);
        check({req, " map"}, pmap, 1);
        check({req, " early"}, early, 0);
        check({req, " spread"}, spread, 0);
        check({req, " tri"}, tri_st, 0);
    endtask

    // Enter power-down, set straps, release
    task automatic restart(input logic [13:0] s);
        pd_req = 1'b1;
        step(2);
        straps = s;
        pd_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pd_req = 1'b0; tick = 1'b1; straps = '0;
        step(3);
        // R1 reset state
        check("R1 valid", valid, 0);
        check("R1 oe", oe, 0);
        check_defaults("R1");
        rst_n = 1'b1;
        step(1);
        check_defaults("R1 pre-capture");
        // R2 capture on second edge after release
        step(1);
        check("R2 capture pci", pci, 0);
        check("R11 tri", tri_st, 1);
        step(T);
        check("R11 valid", valid, 1);
        check("R11 oe held off", oe, 0);

        // R4 exact turnaround with tick in the capture cycle
        restart(VEC[0][24:11]);
        step(1 + T);
        check("R4 not yet valid", valid, 0);
        check("R5 oe off before valid", oe, 0);
        step(1);
        check("R4 valid", valid, 1);
        check("R5 oe on", oe, OE_ON);

        // R3 hold between captures
        straps = '0;
        step(5);
        check("R3 pci held", pci, 3);
        check("R3 tri held", tri_st, 0);
        check("R3 oe", oe, OE_ON);

        // R10 power-down
        pd_req = 1'b1;
        step(1);
        check("R10 valid", valid, 0);
        check("R10 oe", oe, 0);
        step(3);
        check("R10 fields held", pci, 3);
        pd_req = 1'b0;
        step(2 + T);
        check("R10 resample pci", pci, 0);
        check("R10 valid again", valid, 1);

        // R4 no ticks means no timeout
        tick = 1'b0;
        restart(VEC[0][24:11]);
        step(20);
        check("R4 stalled", valid, 0);
        tick = 1'b1;
        step(T - 1);
        check("R4 one tick short", valid, 0);
        step(1);
        check("R4 after ticks", valid, 1);

        // R10 power-down during turnaround restarts the count
        restart(VEC[0][24:11]);
        step(3);
        pd_req = 1'b1;
        step(1);
        pd_req = 1'b0;
        step(1 + T);
        check("R10 count restarted", valid, 0);
        step(1);
        check("R10 valid after full count", valid, 1);

        // Table walk: R6 R7 R8 R9 R5 R11
        for (int i = 0; i < 7; i++) begin
            restart(VEC[i][24:11]);
            step(2 + T);
            check("R6 pci", pci, VEC[i][10:8]);
            check("R7 aud", aud, VEC[i][7:6]);
            check("R9 fix", fix, VEC[i][5]);
            check("R8 map", pmap, VEC[i][4:3]);
            check("R9 early", early, VEC[i][2]);
            check("R9 spread", spread, VEC[i][1]);
            check("R11 tri", tri_st, VEC[i][0]);
            check("R5 oe", oe, VEC[i][0] ? 7'b0 : OE_ON);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule